// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block decides which memory answers a bus access on a 16-bit processor bus with an active-low address strobe. Straight after reset, nonvolatile memory (ROM) is laid over the whole map. This lets the processor read its initial stack pointer from address 0x000000 and its start address from 0x000004 out of ROM. RAM is not yet visible.

A shift chain counts completed bus cycles. The chain is cleared by reset, and a one enters it each time the strobe is released. When the last stage is set, the map moves from the boot state to the run state, and it stays there until the next reset. In the run state, a single high address line (address bit 21, presented on `map_bit_i`) chooses between the two memories. RAM answers when that bit is low, so it sits from address zero upward. This makes the exception vector table in the first kilobyte (0x000000 to 0x0003FF) writable by software.

The selects are decoded from the map state and the address bit alone. They are not gated by the strobe, so a select is valid early in the bus cycle. This suits devices that need chip select before read or write. The strobe is sampled on the block clock, and its release (low to high) marks the end of a bus cycle.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While reset is asserted and directly after it, `rom_sel_n` is 0 and `ram_sel_n` is 1, whatever the value of `map_bit_i`.
- R2: In the boot state, ROM is selected (`rom_sel_n` = 0, `ram_sel_n` = 1) for every access, with `map_bit_i` either 0 or 1. This covers the vector reads at addresses 0, 2, 4 and 6.
- R3: The shift chain advances only on a release of `as_n` (a 0 sampled on one clock edge and a 1 on the next). Holding `as_n` low for any number of cycles does not advance it, and holding it high does not advance it either.
- R4: The map leaves the boot state on the 4th strobe release after reset (`BOOT_READS` = 4). The selects change exactly 2 clock edges after the first edge that samples `as_n` = 1 in that release. At the first of those 2 edges, ROM is still selected.
- R5: In the run state, `map_bit_i` = 0 selects RAM (`ram_sel_n` = 0). This covers address 0x000000 and the vector region up to 0x0003FF. `map_bit_i` = 1 selects ROM (`rom_sel_n` = 0).
- R6: The run state is sticky. Any later strobe activity leaves the map in the run state until reset.
- R7: Exactly one of `rom_sel_n` and `ram_sel_n` is low in every cycle. The two selects are never asserted together.
- R8: Asserting reset again at any time returns the map to the boot state. The next 4 strobe releases end the overlay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `as_n` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Active-low address strobe from the processor |
| map_bit_i | input | 1 | Address bit 21; picks ROM (1) or RAM (0) in the run state |
| rom_sel_n | output | 1 | Active-low ROM select |
| ram_sel_n | output | 1 | Active-low RAM select |

## Verification
The critical overlap happens when the 4th strobe release arrives while the next access is already presenting address zero. In that cycle, the chain completion and the address decode act together. The bench provokes this by holding address 0 with `map_bit_i` low across the release. It then samples the selects at each of the next two clock edges. The first sample must still show ROM, and the second must show RAM. A second overlap, a reset that lands in the run state during an access to address zero, is judged by requiring ROM right after reset.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

    typedef enum logic [0:0] {
        MAP_BOOT = 1'b0,
        MAP_RUN  = 1'b1
    } map_state_e;

endpackage

// File: rtl/ovl_strobe_edge.sv
module ovl_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    output logic release_o
);
    logic as_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q <= 1'b1;
        end else begin
            as_q <= as_n;
        end
    end

    // Low on the previous edge, high on this one: a bus cycle has ended.
    assign release_o = as_n & ~as_q;
endmodule

// File: rtl/ovl_shift_chain.sv
module ovl_shift_chain #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [STAGES-1:0] chain_o
);
    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic feed;
        if (g == 0) begin : g_head
            assign feed = 1'b1;
        end else begin : g_link
            assign feed = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= 1'b0;
            end else if (advance) begin
                stage_q[g] <= feed;
            end
        end
    end

    assign chain_o = stage_q;
endmodule

// File: rtl/ovl_map_decode.sv
module ovl_map_decode
    import boot_overlay_pkg::*;
(
    input  map_state_e state,
    input  logic       map_bit,
    output logic       rom_sel_n,
    output logic       ram_sel_n
);
    always_comb begin
        rom_sel_n = 1'b0;
        ram_sel_n = 1'b1;
        unique case (state)
            MAP_BOOT: begin
                rom_sel_n = 1'b0;
                ram_sel_n = 1'b1;
            end
            MAP_RUN: begin
                rom_sel_n = ~map_bit;
                ram_sel_n = map_bit;
            end
            default: begin
                rom_sel_n = 1'b0;
                ram_sel_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import boot_overlay_pkg::*;
#(
    parameter int BOOT_READS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic map_bit_i,
    output logic rom_sel_n,
    output logic ram_sel_n
);
    localparam int LAST = BOOT_READS - 1;

    logic                  strobe_release;
    logic [BOOT_READS-1:0] chain_q;
    logic                  chain_done;
    map_state_e            state_q;
    map_state_e            state_d;

    ovl_strobe_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .release_o (strobe_release)
    );

    ovl_shift_chain #(.STAGES(BOOT_READS)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (strobe_release),
        .chain_o (chain_q)
    );

    assign chain_done = chain_q[LAST];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MAP_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: BOOT -> RUN on chain completion; RUN holds until reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_BOOT: if (chain_done) state_d = MAP_RUN;
            MAP_RUN:  state_d = MAP_RUN;
            default:  state_d = MAP_BOOT;
        endcase
    end

    // Outputs
    ovl_map_decode u_dec (
        .state     (state_q),
        .map_bit   (map_bit_i),
        .rom_sel_n (rom_sel_n),
        .ram_sel_n (ram_sel_n)
    );
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk
    import boot_overlay_pkg::*;
#(
    parameter int STAGES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic              map_bit_i,
    input logic              rom_sel_n,
    input logic              ram_sel_n,
    input map_state_e        state_q,
    input logic [STAGES-1:0] chain_q
);
    // R7
    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel_n != ram_sel_n);

    // R2
    a_r2_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_BOOT) |-> (!rom_sel_n && ram_sel_n));

    // R3
    a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> $stable(chain_q));

    // R4
    a_r4_leave_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_q[STAGES-1] && state_q == MAP_BOOT) |=> (state_q == MAP_RUN));

    // R5
    a_r5_ram_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_RUN && !map_bit_i) |-> (!ram_sel_n));

    // R6
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_RUN) |=> (state_q == MAP_RUN));
endmodule

bind boot_overlay_decoder boot_overlay_chk #(.STAGES(BOOT_READS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (as_n),
    .map_bit_i (map_bit_i),
    .rom_sel_n (rom_sel_n),
    .ram_sel_n (ram_sel_n),
    .state_q   (state_q),
    .chain_q   (chain_q)
);

// File: tb/test_boot_overlay_decoder.sv
module test_boot_overlay_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_n = 1'b1;
    logic map_bit_i = 1'b0;
    logic rom_sel_n;
    logic ram_sel_n;
    logic [23:0] addr = 24'h0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    boot_overlay_decoder i_boot_overlay_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .map_bit_i (map_bit_i),
        .rom_sel_n (rom_sel_n),
        .ram_sel_n (ram_sel_n)
    );

    always_comb map_bit_i = addr[21];

    // exp_rom = 1 means ROM expected, RAM idle (R7 folded in)
    task automatic chk(input string req, input bit exp_rom);
        logic er, em;
        er = exp_rom ? 1'b0 : 1'b1;
        em = exp_rom ? 1'b1 : 1'b0;
        n_checks++;
        if (rom_sel_n !== er || ram_sel_n !== em) begin
            n_errors++;
            $display("FAIL %s addr=%h rom_sel_n/ram_sel_n actual=%b%b expected=%b%b",
                     req, addr, rom_sel_n, ram_sel_n, er, em);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        as_n  = 1'b1;
        #1;
        addr = 24'h200000; #1; chk("R1 in reset bit21=1", 1'b1);
        addr = 24'h000000; #1; chk("R1 in reset bit21=0", 1'b1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b1);
    endtask

    // One bus cycle: strobe low for 'low' clocks, then released at a negedge.
    task automatic bus_cycle(input logic [23:0] a, input int low, input string req, input bit exp_rom);
        @(negedge clk);
        addr = a;
        as_n = 1'b0;
        repeat (low) @(negedge clk);
        chk(req, exp_rom);
        as_n = 1'b1;
    endtask

    task automatic t_boot_reads();
        do_reset();
        bus_cycle(24'h000000, 2, "R2 vector read 0", 1'b1);
        bus_cycle(24'h000002, 2, "R2 vector read 2", 1'b1);
        bus_cycle(24'h200004, 2, "R2 read bit21=1", 1'b1);
        // R3: strobe held low for a long time does not end the overlay
        bus_cycle(24'h000006, 30, "R3 long low hold", 1'b1);
        // 4th release happens now at this negedge; keep address 0 presented
        addr = 24'h000000;
        @(negedge clk);
        chk("R4 one edge after release still ROM", 1'b1);
        @(negedge clk);
        chk("R4 two edges after release RAM at 0", 1'b0);
    endtask

    task automatic t_run_map();
        bus_cycle(24'h0003FE, 2, "R5 vector region RAM", 1'b0);
        bus_cycle(24'h200000, 2, "R5 bit21=1 ROM", 1'b1);
        bus_cycle(24'h000004, 2, "R5 vector 4 RAM", 1'b0);
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 10; i++) bus_cycle(24'h000000, 1, "R6 strobe activity", 1'b0);
        // strobe idle high for a while
        repeat (20) @(negedge clk);
        addr = 24'h000000; #1;
        chk("R6 idle stays run", 1'b0);
        // R3: strobe high only, chain untouched - verified by sticky run
    endtask

    task automatic t_reset_again();
        // reset during an access to 0 in the run state
        @(negedge clk);
        addr = 24'h000000;
        as_n = 1'b0;
        @(negedge clk);
        chk("R8 before reset RAM", 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R8 reset restores ROM", 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        as_n  = 1'b1;
        @(negedge clk);
        chk("R8 after reset ROM", 1'b1);
        for (int i = 0; i < 3; i++) bus_cycle(24'h000000, 1, "R8 boot reads again", 1'b1);
        bus_cycle(24'h000000, 1, "R8 4th read ROM", 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk("R8 overlay ends again", 1'b0);
    endtask

    initial begin
        t_boot_reads();
        t_run_map();
        t_sticky();
        t_reset_again();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule